// File: doc/BRIEF.md
# Open-Page DRAM Access Sequencer

This block sits in front of a single DRAM array and turns word-wide read and write requests into the timed phases the array needs: closing the current row (precharge), opening a row (row strobe) and accessing a word within the open row (column strobe). A request carries a word address whose upper bits select the row and whose lower bits select the column. The block keeps the most recently opened row active, so a later request to the same row needs only the column phase. A request to a different row pays the full close, open and access sequence.

The array loses charge over time, so a free-running interval timer asks for a refresh of one row at a time. The refresh waits for the next idle point, takes priority over a waiting request, and opens the next row in a wrapping row counter. A refreshed row is not kept as the open page, so the access that follows is always a page miss. Only one request is in flight at a time. Each completion raises a one-cycle valid pulse, carries the read word for reads, and reports whether the access found its row already open. The phase outputs show which phase the array is in and which row is being opened.

Top module: `pageDramSeq`

## Requirements
- R1: While reset is held and right after it, `reqReady` is 1, `cplValid` is 0, `cmdRefresh` is 0 and `cmdPhase` is 2'b00 (no phase).
- R2: Row field = `reqAddr[ROW_BITS+COL_BITS-1:COL_BITS]`, column field = `reqAddr[COL_BITS-1:0]`; while `cmdPhase` is 2'b10 for a request, `cmdRow` equals that request's row field.
- R3: The first access after reset (array precharged, no row open) runs row strobe then column strobe; `cplValid` rises T_RAS+T_CAS cycles after the acceptance edge, with `cplHit` 0, and the first phase shown is 2'b10.
- R4: A request to a row other than the open row runs precharge (2'b01), row strobe (2'b10), column strobe (2'b11); `cplValid` rises T_PRE+T_RAS+T_CAS cycles after acceptance, with `cplHit` 0.
- R5: A request whose row equals the open row shows column strobe (2'b11) in the first cycle after acceptance, no row strobe, and completes T_CAS cycles after acceptance with `cplHit` 1.
- R6: A read returns on `cplRdata` the word most recently written to that address; writes also complete with a `cplValid` pulse.
- R7: After a request is accepted, `reqReady` stays 0 in every cycle before its `cplValid` pulse.
- R8: A refresh is requested every T_REFI cycles; it begins at the next idle point ahead of any waiting request, runs precharge first if a row is open, then holds `cmdRefresh` 1 for T_RAS cycles; successive refresh starts are spaced T_REFI cycles apart within the length of one miss access plus a precharge.
- R9: The refreshed row, shown on `cmdRow` while `cmdRefresh` is 1, is 0 for the first refresh and increments by one per refresh, wrapping from 2^ROW_BITS-1 to 0.
- R10: The first access after a refresh is a page miss costing T_PRE+T_RAS+T_CAS cycles with `cplHit` 0.
- R11: `cplValid` is high for exactly one cycle per completed request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_BITS+COL_BITS | Word address, row field above column field |
| reqWdata | input | DATA_W | Write word |
| cplValid | output | 1 | One-cycle completion pulse |
| cplHit | output | 1 | Completed access found its row open |
| cplRdata | output | DATA_W | Read word, valid with `cplValid` on reads |
| cmdPhase | output | 2 | Array phase: 00 none, 01 precharge, 10 row strobe, 11 column strobe |
| cmdRow | output | ROW_BITS | Row being opened during a row strobe, else 0 |
| cmdRefresh | output | 1 | Row strobe in progress belongs to a refresh |

## Verification
The hardest situation to reach from the ports is a refresh colliding with traffic: the timer is free-running and invisible, so the bench cannot choose when a refresh lands. It keeps requests arriving back to back for well over sixteen refresh intervals, watches `cmdRefresh` to learn when each refresh happened, and from that predicts the miss and its longer latency on the next access, the spacing of refresh starts under load, and the row counter wrapping. An idle stretch then lets several refreshes run with no open row before traffic resumes.

// File: rtl/pageDramPkg.sv
package pageDramPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_REF
  } seqState_t;

  typedef enum logic [1:0] {
    PH_NONE = 2'b00,
    PH_PRE  = 2'b01,
    PH_ROW  = 2'b10,
    PH_COL  = 2'b11
  } phase_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic latchReq;  // request accepted this cycle
    logic preDone;   // last precharge cycle
    logic rowOpen;   // last row-strobe cycle of an access
    logic colDone;   // last column-strobe cycle
    logic refDone;   // last row-strobe cycle of a refresh
    logic rowDrive;  // access row strobe in progress
    logic refDrive;  // refresh row strobe in progress
  } strobes_t;

endpackage

// File: rtl/pageDramCtrl.sv
module pageDramCtrl
  import pageDramPkg::*;
#(
  parameter int T_PRE  = 3,
  parameter int T_RAS  = 3,
  parameter int T_CAS  = 2,
  parameter int T_REFI = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pageHit,
  input  logic       needPre,
  output logic       reqReady,
  output strobes_t   strb,
  output logic [1:0] cmdPhase,
  output logic       cmdRefresh
);

  localparam int T_MAX0 = (T_PRE > T_RAS) ? T_PRE : T_RAS;
  localparam int T_MAX  = (T_MAX0 > T_CAS) ? T_MAX0 : T_CAS;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam int TMR_W  = (T_REFI > 1) ? $clog2(T_REFI) : 1;

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             opRef, opRefNxt;
  logic [TMR_W-1:0] tmr;
  logic             refPend;
  logic             last;
  logic             accept;
  logic             refStart;

  function automatic logic [CNT_W-1:0] loadFor(seqState_t s);
    case (s)
      ST_PRE:  return CNT_W'(T_PRE - 1);
      ST_ACT:  return CNT_W'(T_RAS - 1);
      ST_REF:  return CNT_W'(T_RAS - 1);
      ST_COL:  return CNT_W'(T_CAS - 1);
      default: return '0;
    endcase
  endfunction

  assign last     = (cnt == '0);
  assign reqReady = (state == ST_IDLE) && !refPend;
  assign accept   = reqValid && reqReady;
  assign refStart = (state == ST_IDLE) && refPend;

  always_comb begin
    stateNxt = state;
    opRefNxt = opRef;
    unique case (state)
      ST_IDLE: begin
        if (refPend) begin
          opRefNxt = 1'b1;
          stateNxt = needPre ? ST_PRE : ST_REF;
        end else if (reqValid) begin
          opRefNxt = 1'b0;
          stateNxt = pageHit ? ST_COL : (needPre ? ST_PRE : ST_ACT);
        end
      end
      ST_PRE:  if (last) stateNxt = opRef ? ST_REF : ST_ACT;
      ST_ACT:  if (last) stateNxt = ST_COL;
      ST_COL:  if (last) stateNxt = ST_IDLE;
      ST_REF:  if (last) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
    if (stateNxt != state)       cntNxt = loadFor(stateNxt);
    else if (state == ST_IDLE)   cntNxt = '0;
    else                         cntNxt = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      opRef <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      opRef <= opRefNxt;
    end
  end

  // Free-running refresh interval timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr     <= '0;
      refPend <= 1'b0;
    end else begin
      if (tmr == TMR_W'(T_REFI - 1)) begin
        tmr     <= '0;
        refPend <= 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
        if (refStart) refPend <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.latchReq = accept;
    strb.preDone  = (state == ST_PRE) && last;
    strb.rowOpen  = (state == ST_ACT) && last;
    strb.colDone  = (state == ST_COL) && last;
    strb.refDone  = (state == ST_REF) && last;
    strb.rowDrive = (state == ST_ACT);
    strb.refDrive = (state == ST_REF);
  end

  always_comb begin
    unique case (state)
      ST_PRE:          cmdPhase = PH_PRE;
      ST_ACT, ST_REF:  cmdPhase = PH_ROW;
      ST_COL:          cmdPhase = PH_COL;
      default:         cmdPhase = PH_NONE;
    endcase
  end

  assign cmdRefresh = (state == ST_REF);

  // R7: an accepted request makes the block busy in the next cycle
  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R5: a page hit goes straight to the column phase
  p_hit_col_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && pageHit) |=> (state == ST_COL));

  // R8: a pending refresh at an idle point wins over any request
  p_refresh_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && refPend) |=> (state == ST_PRE || state == ST_REF));

  // R10: during a refresh no row counts as open
  p_ref_no_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REF) |-> !pageHit);

endmodule

// File: rtl/pageDramPath.sv
module pageDramPath
  import pageDramPkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobes_t                     strb,
  input  logic                         reqWrite,
  input  logic [ROW_BITS+COL_BITS-1:0] reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  output logic                         pageHit,
  output logic                         needPre,
  output logic                         cplValid,
  output logic                         cplHit,
  output logic [DATA_W-1:0]            cplRdata,
  output logic [ROW_BITS-1:0]          cmdRow
);

  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int ROWS   = 1 << ROW_BITS;

  logic [ADDR_W-1:0]   curAddr;
  logic                curWrite;
  logic [DATA_W-1:0]   curWdata;
  logic                curHit;
  logic                openValid;
  logic [ROW_BITS-1:0] openRow;
  logic                needPreQ;
  logic [ROW_BITS-1:0] refRow;
  logic [DATA_W-1:0]   mem [WORDS];

  logic [ROW_BITS-1:0] inRow;
  logic [ROW_BITS-1:0] curRow;

  assign inRow   = reqAddr[ADDR_W-1:COL_BITS];
  assign curRow  = curAddr[ADDR_W-1:COL_BITS];
  assign pageHit = openValid && (inRow == openRow);
  assign needPre = needPreQ;

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWrite <= 1'b0;
      curWdata <= '0;
      curHit   <= 1'b0;
    end else if (strb.latchReq) begin
      curAddr  <= reqAddr;
      curWrite <= reqWrite;
      curWdata <= reqWdata;
      curHit   <= pageHit;
    end
  end

  // Open-page and precharge tracking, refresh row counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      openValid <= 1'b0;
      openRow   <= '0;
      needPreQ  <= 1'b0;
      refRow    <= '0;
    end else begin
      if (strb.preDone) begin
        openValid <= 1'b0;
        needPreQ  <= 1'b0;
      end
      if (strb.rowOpen) begin
        openValid <= 1'b1;
        openRow   <= curRow;
        needPreQ  <= 1'b1;
      end
      if (strb.refDone) begin
        openValid <= 1'b0;
        needPreQ  <= 1'b1;
        refRow    <= (refRow == ROW_BITS'(ROWS - 1)) ? '0 : refRow + 1'b1;
      end
    end
  end

  // Behavioural array storage
  always_ff @(posedge clk) begin
    if (strb.colDone && curWrite) mem[curAddr] <= curWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cplValid <= 1'b0;
      cplHit   <= 1'b0;
      cplRdata <= '0;
    end else begin
      cplValid <= strb.colDone;
      cplHit   <= strb.colDone && curHit;
      if (strb.colDone && !curWrite) cplRdata <= mem[curAddr];
    end
  end

  always_comb begin
    if (strb.rowDrive)      cmdRow = curRow;
    else if (strb.refDrive) cmdRow = refRow;
    else                    cmdRow = '0;
  end

  // R4: the column phase only ever runs on an open row
  p_col_open_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.colDone |-> openValid);

  // R11: completion is a single-cycle pulse
  p_cpl_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |=> !cplValid);

endmodule

// File: rtl/pageDramSeq.sv
module pageDramSeq
  import pageDramPkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 16,
  parameter int T_PRE    = 3,
  parameter int T_RAS    = 3,
  parameter int T_CAS    = 2,
  parameter int T_REFI   = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic                         reqWrite,
  input  logic [ROW_BITS+COL_BITS-1:0] reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  output logic                         cplValid,
  output logic                         cplHit,
  output logic [DATA_W-1:0]            cplRdata,
  output logic [1:0]                   cmdPhase,
  output logic [ROW_BITS-1:0]          cmdRow,
  output logic                         cmdRefresh
);

  strobes_t strb;
  logic     pageHit;
  logic     needPre;

  pageDramCtrl #(
    .T_PRE (T_PRE),
    .T_RAS (T_RAS),
    .T_CAS (T_CAS),
    .T_REFI(T_REFI)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .pageHit   (pageHit),
    .needPre   (needPre),
    .reqReady  (reqReady),
    .strb      (strb),
    .cmdPhase  (cmdPhase),
    .cmdRefresh(cmdRefresh)
  );

  pageDramPath #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS),
    .DATA_W  (DATA_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .pageHit (pageHit),
    .needPre (needPre),
    .cplValid(cplValid),
    .cplHit  (cplHit),
    .cplRdata(cplRdata),
    .cmdRow  (cmdRow)
  );

endmodule

// File: tb/pageDramSeq_tb.sv
`timescale 1ns/1ps
module pageDramSeq_tb;

  localparam int ROW_BITS = 4;
  localparam int COL_BITS = 3;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = ROW_BITS + COL_BITS;
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int WORDS    = 1 << ADDR_W;
  localparam int T_PRE    = 3;
  localparam int T_RAS    = 3;
  localparam int T_CAS    = 2;
  localparam int T_REFI   = 64;
  localparam int GAP_TOL  = T_PRE + T_RAS + T_CAS + T_PRE;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                reqValid = 1'b0;
  logic                reqReady;
  logic                reqWrite = 1'b0;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic [DATA_W-1:0]   reqWdata = '0;
  logic                cplValid;
  logic                cplHit;
  logic [DATA_W-1:0]   cplRdata;
  logic [1:0]          cmdPhase;
  logic [ROW_BITS-1:0] cmdRow;
  logic                cmdRefresh;

  always #2.5 clk = ~clk;

  pageDramSeq #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W),
    .T_PRE(T_PRE), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_REFI(T_REFI)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cplValid(cplValid), .cplHit(cplHit), .cplRdata(cplRdata),
    .cmdPhase(cmdPhase), .cmdRow(cmdRow), .cmdRefresh(cmdRefresh)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference model state
  bit                mOpen = 1'b0;
  logic [ROW_BITS-1:0] mRow = '0;
  bit                mNeedPre = 1'b0;
  logic [DATA_W-1:0] shadow [WORDS];
  bit                shadowOk [WORDS];
  int                refCount = 0;
  int                refUsed = 0;
  int                expRefRow = 0;
  int                cyc = 0;
  int                lastRefCyc = 0;
  bit                prevRef = 1'b0;

  // {write, addr, data, expected hit}
  localparam logic [ADDR_W+DATA_W+1:0] VECS [0:8] = '{
    {1'b1, 7'h11, 16'hA1C3, 1'b0},  // closed-page miss (R3)
    {1'b0, 7'h11, 16'h0000, 1'b1},  // hit read back (R5, R6)
    {1'b1, 7'h15, 16'h5E77, 1'b1},  // hit write, other column
    {1'b1, 7'h38, 16'h0BAD, 1'b0},  // row change (R4)
    {1'b0, 7'h15, 16'h0000, 1'b0},  // back to row 2
    {1'b0, 7'h11, 16'h0000, 1'b1},
    {1'b0, 7'h38, 16'h0000, 1'b0},
    {1'b1, 7'h3F, 16'hFACE, 1'b1},
    {1'b0, 7'h3F, 16'h0000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) cyc++;

  // Refresh monitor: row sequence and spacing
  always @(negedge clk) begin
    if (!rstN) begin
      prevRef = 1'b0;
    end else begin
      if (cmdRefresh && !prevRef) begin
        check("R9 refresh row", 32'(cmdRow), 32'(expRefRow));
        check("R8 refresh shown as row strobe", 32'(cmdPhase), 32'h2);
        if (refCount > 0)
          check("R8 refresh spacing in window",
                32'((cyc - lastRefCyc >= T_REFI - GAP_TOL) && (cyc - lastRefCyc <= T_REFI + GAP_TOL)), 32'h1);
        lastRefCyc = cyc;
        expRefRow  = (expRefRow + 1) % ROWS;
        refCount++;
      end
      prevRef = cmdRefresh;
    end
  end

  // tabHit: 0/1 from the table, -1 means use the model
  task automatic doAccess(input logic wr, input logic [ADDR_W-1:0] addr,
                          input logic [DATA_W-1:0] wd, input int tabHit);
    logic [ROW_BITS-1:0] row;
    bit   expHit;
    bit   sawRef;
    int   expLat;
    int   expPh;
    int   lat;
    string tag;
    row = addr[ADDR_W-1:COL_BITS];
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqWdata = wd;
    while (!reqReady) @(negedge clk);
    sawRef = (refCount != refUsed);
    if (sawRef) begin
      mOpen    = 1'b0;
      mNeedPre = 1'b1;
      refUsed  = refCount;
    end
    expHit = mOpen && (mRow == row);
    if (tabHit >= 0 && !sawRef) check("R5 table hit expectation vs model", 32'(expHit), 32'(tabHit));
    expLat = expHit ? T_CAS : ((mNeedPre ? T_PRE : 0) + T_RAS + T_CAS);
    expPh  = expHit ? 3 : (mNeedPre ? 1 : 2);
    tag    = sawRef ? "R10" : (expHit ? "R5" : (mNeedPre ? "R4" : "R3"));
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " first phase"}, 32'(cmdPhase), 32'(expPh));
    if (expPh == 2) check("R2 row strobe row field", 32'(cmdRow), 32'(row));
    lat = 0;
    while (!cplValid && lat < 64) begin
      check("R7 ready low while busy", 32'(reqReady), 32'h0);
      @(negedge clk);
      lat++;
    end
    check({tag, " latency"}, 32'(lat), 32'(expLat));
    check({tag, " hit flag"}, 32'(cplHit), 32'(expHit));
    if (!wr && shadowOk[addr]) check("R6 read data", 32'(cplRdata), 32'(shadow[addr]));
    if (wr) begin
      shadow[addr]   = wd;
      shadowOk[addr] = 1'b1;
    end
    mOpen    = 1'b1;
    mRow     = row;
    mNeedPre = 1'b1;
    @(negedge clk);
    check("R11 completion pulse one cycle", 32'(cplValid), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) shadowOk[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(reqReady), 32'h1);
    check("R1 no completion in reset", 32'(cplValid), 32'h0);
    check("R1 no phase in reset", 32'(cmdPhase), 32'h0);
    check("R1 no refresh in reset", 32'(cmdRefresh), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(reqReady), 32'h1);
    check("R1 idle phase after reset", 32'(cmdPhase), 32'h0);

    // Vector table
    for (int v = 0; v < 9; v++) begin
      doAccess(VECS[v][ADDR_W+DATA_W+1], VECS[v][ADDR_W+DATA_W:DATA_W+1],
               VECS[v][DATA_W:1], int'(VECS[v][0]));
    end

    // Sustained traffic across many refresh intervals (R8, R9, R10)
    for (int i = 0; i < 200; i++) begin
      logic [ADDR_W-1:0] a;
      int base;
      base = (i % 2 == 1) ? i - 1 : i;
      a = {ROW_BITS'(((base / 3) * 5) % ROWS), COL_BITS'((base * 3) % 8)};
      doAccess((i % 2) == 0, a, DATA_W'(16'h3C00 + i * 97), -1);
    end

    // Idle stretch: refreshes run with nothing open, then traffic resumes
    repeat (300) @(negedge clk);
    check("R8 refreshes during idle", 32'(refCount > 20), 32'h1);
    doAccess(1'b0, 7'h15, '0, -1);
    doAccess(1'b0, 7'h11, '0, -1);
    doAccess(1'b1, 7'h70, 16'h1234, -1);
    doAccess(1'b0, 7'h70, '0, -1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule